// File: doc/BRIEF.md
# Pattern-Locking Bit Error Rate Receiver

This block sits on the receive side of a serial test path and checks a bit stream against one of a fixed set of test patterns. While it is searching, every qualified input bit goes into a local history register. After a run of correct predictions it declares lock. From then on the history register runs on its own predictions, so a received error cannot corrupt the reference. While locked it counts received bits and mismatched bits.

Software-facing control bits act on their rising edges. One edge starts a fresh acquisition. Another edge copies the running bit and error totals into holding registers and restarts the running totals from zero in the same clock. Three single-cycle interrupt pulses report a change of lock state, the first bit error of a counting period, and counter saturation. Each pulse has its own enable. The asynchronous reset input passes through a two-stage synchronizer before it reaches the core, so the core leaves reset two clocks after `rst_n` rises.

Top module: `prbs_rx_monitor`

## Requirements
- R1: The pattern is chosen by `bank_sel` and `pat_sel`. With `bank_sel`=0 the codes are: 000 = 7-stage sequence (x^7+x^6+1), 001 = 11-stage (x^11+x^9+1), 010 = 15-stage (x^15+x^14+1), 011 = 20-stage (x^20+x^17+1), 100 = word of REP_LEN bits repeated, 101 = two REP_LEN-bit words alternating (period 2*REP_LEN). With `bank_sel`=1 the codes are: 000 = 9-stage (x^9+x^5+1), 001 = 20-stage (x^20+x^3+1), 010 = 23-stage (x^23+x^18+1). In each sequence, bit n is the XOR of bit n-a and bit n-b, where a and b are the two exponents.
- R2: When `rx_inv` is 1, every input bit is complemented before it is compared.
- R3: While searching, qualified bits feed the reference history. Lock (`sync`=1) is declared on the clock edge of the 32nd consecutive correct prediction and no earlier.
- R4: While locked, bits are grouped into 64-bit windows, starting with the first bit after lock. The block loses lock on the 6th mismatch inside one window. Fewer mismatches than that per window keep lock.
- R5: A 0-to-1 change of `resync` drops lock on that edge and restarts the search. Holding `resync` high has no further effect.
- R6: The codes left unassigned in R1 (bank 0: 110 and 111; bank 1: 011 to 111) force `sync` to 0 for as long as they are selected.
- R7: Bits and errors are counted only while locked. Each qualified bit adds one to the bit total, and each mismatch also adds one to the error total.
- R8: A 0-to-1 change of `load_cnt` copies both running totals to `bit_count` and `err_count`, restarts the running totals from zero in that same clock (a bit arriving in that clock counts toward the new period), and clears `cnt_ovf`.
- R9: A running total that is all ones does not wrap. The attempt to go past all ones sets `cnt_ovf`, which stays set until the next load.
- R10: `irq_sync` is a one-cycle pulse, seen in the same cycle as the new `sync` value, whenever lock is gained or lost.
- R11: `irq_err` pulses for one cycle on the first counted error after reset or after each load, and not for later errors of that period.
- R12: `irq_ovf` pulses for one cycle when `cnt_ovf` goes from 0 to 1.
- R13: Each pulse is produced only if its enable (`ie_sync`, `ie_err`, `ie_ovf`) was 1 in the cycle of the triggering event. The counts and flags are unaffected by the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Qualifies `rx_data` for this clock |
| rx_data | input | 1 | Serial data bit |
| bank_sel | input | 1 | Pattern bank |
| pat_sel | input | 3 | Pattern code within the bank |
| rx_inv | input | 1 | Complement incoming bits |
| resync | input | 1 | Rising edge restarts acquisition |
| load_cnt | input | 1 | Rising edge snapshots and clears the totals |
| ie_sync | input | 1 | Enable for `irq_sync` |
| ie_err | input | 1 | Enable for `irq_err` |
| ie_ovf | input | 1 | Enable for `irq_ovf` |
| sync | output | 1 | Lock status |
| bit_count | output | CNT_W (32) | Bit total captured at the last load |
| err_count | output | CNT_W (32) | Error total captured at the last load |
| cnt_ovf | output | 1 | Sticky saturation flag |
| irq_sync | output | 1 | Lock-change pulse |
| irq_err | output | 1 | First-error pulse |
| irq_ovf | output | 1 | Saturation pulse |

## Verification
The bench checks the lock point exactly: no lock after 31 good bits and lock on the 32nd. A design that is off by one in its run counter, or that still trusts stale history, fails here. Loss of lock is tested with five errors in one window, which must be survived, and six errors in the next window, which must drop lock. A wrong window length or threshold either keeps lock too long or drops it early. Saturation is driven past the top of a reduced-width counter: a wrapping counter reads back as small, and a missing sticky flag or a repeated interrupt is caught. The edge-only controls are exercised by holding `resync` high through a full acquisition, and the first-error interrupt is exercised both with its enable off and after re-arming by a load.

// File: rtl/prbs_rx_pkg.sv
package prbs_rx_pkg;

  typedef enum logic [3:0] {
    PAT_P7, PAT_P9, PAT_P11, PAT_P15, PAT_P20A, PAT_P20B,
    PAT_P23, PAT_REP, PAT_ALT, PAT_BAD
  } pat_e;

  typedef enum logic {ST_HUNT, ST_LOCK} sync_e;

  function automatic pat_e pat_decode(input logic bank, input logic [2:0] code);
    pat_e p;
    if (!bank) begin
      case (code)
        3'd0:    p = PAT_P7;
        3'd1:    p = PAT_P11;
        3'd2:    p = PAT_P15;
        3'd3:    p = PAT_P20B;
        3'd4:    p = PAT_REP;
        3'd5:    p = PAT_ALT;
        default: p = PAT_BAD;
      endcase
    end else begin
      case (code)
        3'd0:    p = PAT_P9;
        3'd1:    p = PAT_P20A;
        3'd2:    p = PAT_P23;
        default: p = PAT_BAD;
      endcase
    end
    return p;
  endfunction

endpackage

// File: rtl/prbs_rx_ref.sv
module prbs_rx_ref
  import prbs_rx_pkg::*;
#(
  parameter int REP_LEN = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic locked,
  input  logic rx_bit,
  input  pat_e pat,
  output logic pred
);
  localparam int HIST_W = 2 * REP_LEN;

  logic [HIST_W-1:0] hist_q, hist_d;

  // bit n is predicted from the bits a and b positions back; hist_q[0] is the newest
  always_comb begin
    case (pat)
      PAT_P7:   pred = hist_q[6]  ^ hist_q[5];
      PAT_P9:   pred = hist_q[8]  ^ hist_q[4];
      PAT_P11:  pred = hist_q[10] ^ hist_q[8];
      PAT_P15:  pred = hist_q[14] ^ hist_q[13];
      PAT_P20A: pred = hist_q[19] ^ hist_q[2];
      PAT_P20B: pred = hist_q[19] ^ hist_q[16];
      PAT_P23:  pred = hist_q[22] ^ hist_q[17];
      PAT_REP:  pred = hist_q[REP_LEN-1];
      PAT_ALT:  pred = hist_q[HIST_W-1];
      default:  pred = 1'b0;
    endcase
  end

  // searching: load from the line; locked: run on its own prediction
  always_comb begin
    hist_d = hist_q;
    if (bit_en) hist_d = {hist_q[HIST_W-2:0], locked ? pred : rx_bit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

endmodule

// File: rtl/prbs_rx_sync.sv
module prbs_rx_sync
  import prbs_rx_pkg::*;
#(
  parameter int SYNC_RUN  = 32,
  parameter int WIN_LEN   = 64,
  parameter int DROP_ERRS = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic miss,
  input  logic restart,
  output logic locked,
  output logic locked_nx
);
  localparam int RUN_W = $clog2(SYNC_RUN + 1);
  localparam int WIN_W = $clog2(WIN_LEN);
  localparam int ERR_W = $clog2(DROP_ERRS + 1);

  sync_e            st_q, st_d;
  logic [RUN_W-1:0] run_q, run_d;
  logic [WIN_W-1:0] win_q, win_d;
  logic [ERR_W-1:0] werr_q, werr_d, werr_sum;

  always_comb begin
    st_d     = st_q;
    run_d    = run_q;
    win_d    = win_q;
    werr_d   = werr_q;
    werr_sum = werr_q + ERR_W'(miss);
    if (restart) begin
      st_d   = ST_HUNT;
      run_d  = '0;
      win_d  = '0;
      werr_d = '0;
    end else if (bit_en) begin
      if (st_q == ST_HUNT) begin
        if (miss) begin
          run_d = '0;
        end else if (run_q == RUN_W'(SYNC_RUN - 1)) begin
          st_d   = ST_LOCK;
          run_d  = '0;
          win_d  = '0;
          werr_d = '0;
        end else begin
          run_d = run_q + 1'b1;
        end
      end else if (werr_sum == ERR_W'(DROP_ERRS)) begin
        st_d   = ST_HUNT;
        run_d  = '0;
        win_d  = '0;
        werr_d = '0;
      end else if (win_q == WIN_W'(WIN_LEN - 1)) begin
        win_d  = '0;
        werr_d = '0;
      end else begin
        win_d  = win_q + 1'b1;
        werr_d = werr_sum;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_HUNT;
      run_q  <= '0;
      win_q  <= '0;
      werr_q <= '0;
    end else begin
      st_q   <= st_d;
      run_q  <= run_d;
      win_q  <= win_d;
      werr_q <= werr_d;
    end
  end

  assign locked    = (st_q == ST_LOCK);
  assign locked_nx = (st_d == ST_LOCK);

endmodule

// File: rtl/prbs_rx_count.sv
module prbs_rx_count #(
  parameter int CNT_W = 32,
  parameter int NCH   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NCH-1:0]            inc,
  input  logic                      snap,
  output logic [NCH-1:0][CNT_W-1:0] run_q,
  output logic [NCH-1:0][CNT_W-1:0] hold_q,
  output logic [NCH-1:0]            sat_hit
);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [CNT_W-1:0] run_r, run_d, hold_r, hold_d, base;
    logic             at_max;

    always_comb begin
      base   = snap ? '0 : run_r;
      at_max = &base;
      run_d  = base + CNT_W'(inc[i] & ~at_max);
      hold_d = snap ? run_r : hold_r;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        run_r  <= '0;
        hold_r <= '0;
      end else begin
        run_r  <= run_d;
        hold_r <= hold_d;
      end
    end

    assign run_q[i]   = run_r;
    assign hold_q[i]  = hold_r;
    assign sat_hit[i] = inc[i] & at_max;
  end

endmodule

// File: rtl/prbs_rx_monitor.sv
module prbs_rx_monitor
  import prbs_rx_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int REP_LEN   = 32,
  parameter int SYNC_RUN  = 32,
  parameter int WIN_LEN   = 64,
  parameter int DROP_ERRS = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             rx_data,
  input  logic             bank_sel,
  input  logic [2:0]       pat_sel,
  input  logic             rx_inv,
  input  logic             resync,
  input  logic             load_cnt,
  input  logic             ie_sync,
  input  logic             ie_err,
  input  logic             ie_ovf,
  output logic             sync,
  output logic [CNT_W-1:0] bit_count,
  output logic [CNT_W-1:0] err_count,
  output logic             cnt_ovf,
  output logic             irq_sync,
  output logic             irq_err,
  output logic             irq_ovf
);

  // reset: asserted at once, released two clocks later
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  pat_e pat;
  logic illegal, rx_bit, pred, miss;
  logic resync_q, load_q, resync_edge, snap;
  logic locked, locked_nx, cnt_bit, cnt_err;
  logic [1:0][CNT_W-1:0] run_tot, hold_tot;
  logic [1:0]            sat_hit;
  logic [CNT_W-1:0]      bit_run, err_run;
  logic ovf_q, ovf_d, ovf_new, armed_q, armed_d;
  logic irq_sync_d, irq_err_d, irq_ovf_d;

  assign pat         = pat_decode(bank_sel, pat_sel);
  assign illegal     = (pat == PAT_BAD);
  assign rx_bit      = rx_data ^ rx_inv;
  assign miss        = rx_bit ^ pred;
  assign resync_edge = resync & ~resync_q;
  assign snap        = load_cnt & ~load_q;

  prbs_rx_ref #(.REP_LEN(REP_LEN)) u_ref (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .bit_en (bit_en),
    .locked (locked),
    .rx_bit (rx_bit),
    .pat    (pat),
    .pred   (pred)
  );

  prbs_rx_sync #(
    .SYNC_RUN  (SYNC_RUN),
    .WIN_LEN   (WIN_LEN),
    .DROP_ERRS (DROP_ERRS)
  ) u_sync (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .bit_en    (bit_en),
    .miss      (miss),
    .restart   (resync_edge | illegal),
    .locked    (locked),
    .locked_nx (locked_nx)
  );

  assign cnt_bit = bit_en & locked;
  assign cnt_err = cnt_bit & miss;

  prbs_rx_count #(.CNT_W(CNT_W), .NCH(2)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .inc     ({cnt_err, cnt_bit}),
    .snap    (snap),
    .run_q   (run_tot),
    .hold_q  (hold_tot),
    .sat_hit (sat_hit)
  );

  assign bit_run = run_tot[0];
  assign err_run = run_tot[1];

  always_comb begin
    ovf_new    = (|sat_hit) & ~ovf_q;
    ovf_d      = (ovf_q & ~snap) | (|sat_hit);
    armed_d    = (armed_q | snap) & ~cnt_err;
    irq_sync_d = ie_sync & (locked_nx ^ locked);
    irq_err_d  = ie_err & cnt_err & (armed_q | snap);
    irq_ovf_d  = ie_ovf & ovf_new;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      resync_q <= 1'b0;
      load_q   <= 1'b0;
      ovf_q    <= 1'b0;
      armed_q  <= 1'b1;
      irq_sync <= 1'b0;
      irq_err  <= 1'b0;
      irq_ovf  <= 1'b0;
    end else begin
      resync_q <= resync;
      load_q   <= load_cnt;
      ovf_q    <= ovf_d;
      armed_q  <= armed_d;
      irq_sync <= irq_sync_d;
      irq_err  <= irq_err_d;
      irq_ovf  <= irq_ovf_d;
    end
  end

  assign sync      = locked;
  assign bit_count = hold_tot[0];
  assign err_count = hold_tot[1];
  assign cnt_ovf   = ovf_q;

endmodule

// File: rtl/prbs_rx_monitor_chk.sv
module prbs_rx_monitor_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_en,
  input logic             bank_sel,
  input logic [2:0]       pat_sel,
  input logic             resync,
  input logic             load_cnt,
  input logic             ie_sync,
  input logic             ie_err,
  input logic             ie_ovf,
  input logic             sync,
  input logic [CNT_W-1:0] bit_count,
  input logic [CNT_W-1:0] bit_run,
  input logic [CNT_W-1:0] err_run,
  input logic             cnt_ovf,
  input logic             irq_sync,
  input logic             irq_err,
  input logic             irq_ovf
);
  logic bad_code;
  assign bad_code = bank_sel ? (pat_sel > 3'd2) : (pat_sel[2:1] == 2'b11);

  AST_RESYNC_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resync) |=> !sync); // R5
  AST_BAD_CODE_NOSYNC: assert property (@(posedge clk) disable iff (!rst_n)
    bad_code |=> !sync); // R6
  AST_IDLE_UNSYNCED: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync && !$rose(load_cnt)) |=> $stable(bit_run)); // R7
  AST_ERR_WITHIN_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    err_run <= bit_run); // R7
  AST_SNAP_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_cnt) |=> (bit_count == $past(bit_run)) && (bit_run <= 1)); // R8
  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((&bit_run) && !$rose(load_cnt)) |=> (&bit_run)); // R9
  AST_SYNC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_sync |-> (sync != $past(sync)) && $past(ie_sync)); // R10
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err |-> $past(ie_err) && $past(bit_en) && $past(sync)); // R11
  AST_OVF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ovf |-> cnt_ovf && $past(ie_ovf) && !$past(cnt_ovf)); // R12

endmodule

bind prbs_rx_monitor prbs_rx_monitor_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .bit_en    (bit_en),
  .bank_sel  (bank_sel),
  .pat_sel   (pat_sel),
  .resync    (resync),
  .load_cnt  (load_cnt),
  .ie_sync   (ie_sync),
  .ie_err    (ie_err),
  .ie_ovf    (ie_ovf),
  .sync      (sync),
  .bit_count (bit_count),
  .bit_run   (bit_run),
  .err_run   (err_run),
  .cnt_ovf   (cnt_ovf),
  .irq_sync  (irq_sync),
  .irq_err   (irq_err),
  .irq_ovf   (irq_ovf)
);

// File: tb/prbs_rx_monitor_test.sv
`timescale 1ns/1ps
module prbs_rx_monitor_test;
  localparam int CW = 12;

  logic clk = 1'b0;
  logic rst_n, bit_en, rx_data, bank_sel, rx_inv, resync, load_cnt;
  logic ie_sync, ie_err, ie_ovf;
  logic [2:0] pat_sel;
  logic sync, cnt_ovf, irq_sync, irq_err, irq_ovf;
  logic [CW-1:0] bit_count, err_count;

  int   n_vec = 0;
  int   n_bad = 0;
  logic done  = 1'b0;
  logic [63:0] g;
  logic        g_bank;
  logic [2:0]  g_ps;

  // {bank, code, invert, bits to count, errors to inject}
  localparam logic [20:0] VEC [9] = '{
    {1'b0, 3'd0, 1'b0, 12'd300, 4'd3},
    {1'b0, 3'd1, 1'b1, 12'd500, 4'd5},
    {1'b0, 3'd2, 1'b0, 12'd400, 4'd0},
    {1'b0, 3'd3, 1'b0, 12'd640, 4'd7},
    {1'b0, 3'd4, 1'b1, 12'd256, 4'd2},
    {1'b0, 3'd5, 1'b0, 12'd512, 4'd4},
    {1'b1, 3'd0, 1'b0, 12'd333, 4'd1},
    {1'b1, 3'd1, 1'b1, 12'd700, 4'd9},
    {1'b1, 3'd2, 1'b0, 12'd900, 4'd6}
  };

  prbs_rx_monitor #(.CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_data(rx_data),
    .bank_sel(bank_sel), .pat_sel(pat_sel), .rx_inv(rx_inv),
    .resync(resync), .load_cnt(load_cnt), .ie_sync(ie_sync),
    .ie_err(ie_err), .ie_ovf(ie_ovf), .sync(sync),
    .bit_count(bit_count), .err_count(err_count), .cnt_ovf(cnt_ovf),
    .irq_sync(irq_sync), .irq_err(irq_err), .irq_ovf(irq_ovf)
  );

  always #4 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic b);
    @(negedge clk);
    rx_data = b;
    bit_en  = 1'b1;
    @(negedge clk);
    bit_en  = 1'b0;
  endtask

  task automatic pulse_load();
    @(negedge clk) load_cnt = 1'b1;
    @(negedge clk) load_cnt = 1'b0;
  endtask

  task automatic set_code(input logic b, input logic [2:0] c);
    @(negedge clk);
    bank_sel = b;
    pat_sel  = c;
  endtask

  task automatic seed_gen();
    case ({g_bank, g_ps})
      4'b0100: g = {2{32'hF0E1_6A35}};
      4'b0101: g = {32'h3C5A_9D01, 32'hC3A5_62FE};
      default: g = 64'hACE1_0000_0000_1357;
    endcase
  endtask

  task automatic gen_bit(output logic b);
    case ({g_bank, g_ps})
      4'b0000: b = g[6]  ^ g[5];
      4'b0001: b = g[10] ^ g[8];
      4'b0010: b = g[14] ^ g[13];
      4'b0011: b = g[19] ^ g[16];
      4'b0100: b = g[31];
      4'b0101: b = g[63];
      4'b1000: b = g[8]  ^ g[4];
      4'b1001: b = g[19] ^ g[2];
      4'b1010: b = g[22] ^ g[17];
      default: b = 1'b0;
    endcase
    g = {g[62:0], b};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic b, e;
    int   ne;
    rst_n = 1'b0; bit_en = 1'b0; rx_data = 1'b0; bank_sel = 1'b0; pat_sel = 3'd0;
    rx_inv = 1'b0; resync = 1'b0; load_cnt = 1'b0;
    ie_sync = 1'b1; ie_err = 1'b1; ie_ovf = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk("reset sync", int'(sync), 0);
    chk("reset bit_count", int'(bit_count), 0);
    chk("reset err_count", int'(err_count), 0);
    chk("reset cnt_ovf", int'(cnt_ovf), 0);
    chk("reset irqs", int'({irq_sync, irq_err, irq_ovf}), 0);

    // vector table: every pattern code, with and without inversion
    for (int i = 0; i < 9; i++) begin
      logic       vb, vinv;
      logic [2:0] vps;
      int         vn, ve;
      vb = VEC[i][20]; vps = VEC[i][19:17]; vinv = VEC[i][16];
      vn = int'(VEC[i][15:4]); ve = int'(VEC[i][3:0]);
      set_code(1'b0, 3'd6);
      rx_inv = vinv;
      g_bank = vb; g_ps = vps;
      seed_gen();
      for (int k = 0; k < 80; k++) begin gen_bit(b); step(b ^ vinv); end
      set_code(vb, vps);
      for (int k = 0; k < 31; k++) begin gen_bit(b); step(b ^ vinv); end
      chk($sformatf("R3 vec%0d no lock after 31", i), int'(sync), 0);
      gen_bit(b); step(b ^ vinv);
      chk($sformatf("R1 R2 R3 vec%0d lock on 32nd", i), int'(sync), 1);
      pulse_load();
      ne = 0;
      for (int k = 0; k < vn; k++) begin
        gen_bit(b);
        e = ((k % 20) == 10) && (ne < ve);
        if (e) ne++;
        step(b ^ vinv ^ e);
      end
      pulse_load();
      chk($sformatf("R7 vec%0d bit total", i), int'(bit_count), vn);
      chk($sformatf("R7 vec%0d error total", i), int'(err_count), ve);
      chk($sformatf("R4 vec%0d sparse errors keep lock", i), int'(sync), 1);
    end

    // all-zero stream on the 7-stage code: the reference stays zero
    rx_inv = 1'b0;
    set_code(1'b0, 3'd7);
    repeat (80) step(1'b0);
    chk("R6 unassigned code never locks", int'(sync), 0);
    set_code(1'b0, 3'd0);
    repeat (31) step(1'b0);
    chk("R3 zeros no lock after 31", int'(sync), 0);
    step(1'b0);
    chk("R3 zeros lock on 32nd", int'(sync), 1);
    chk("R10 lock pulse", int'(irq_sync), 1);
    step(1'b0);
    chk("R10 pulse lasts one cycle", int'(irq_sync), 0);
    pulse_load();
    // window 0 (idx 1..63 relative to here after the bit above): use a fresh window
    repeat (63) step(1'b0);
    step(1'b1);
    chk("R11 first error pulse", int'(irq_err), 1);
    step(1'b1);
    chk("R11 second error silent", int'(irq_err), 0);
    repeat (3) step(1'b1);
    repeat (59) step(1'b0);
    chk("R4 five errors in a window keep lock", int'(sync), 1);
    repeat (5) step(1'b1);
    chk("R4 five errors next window keep lock", int'(sync), 1);
    step(1'b1);
    chk("R4 sixth error drops lock", int'(sync), 0);
    chk("R10 loss pulse", int'(irq_sync), 1);
    pulse_load();
    chk("R7 R8 bits over two windows", int'(bit_count), 64 + 63 + 6);
    chk("R7 R8 errors over two windows", int'(err_count), 11);

    repeat (20) step(1'b0);
    pulse_load();
    chk("R7 nothing counted while searching", int'(bit_count), 0);

    @(negedge clk) resync = 1'b1;
    repeat (31) step(1'b0);
    chk("R5 held resync no lock at 31", int'(sync), 0);
    step(1'b0);
    chk("R5 held resync lock at 32", int'(sync), 1);
    repeat (40) step(1'b0);
    chk("R5 held high no further effect", int'(sync), 1);
    @(negedge clk) resync = 1'b0;
    step(1'b0);
    @(negedge clk) resync = 1'b1;
    @(negedge clk);
    chk("R5 new edge drops lock", int'(sync), 0);

    rx_inv = 1'b1;
    repeat (32) step(1'b1);
    chk("R2 inverted ones lock", int'(sync), 1);

    ie_err = 1'b0;
    pulse_load();
    step(1'b0);
    chk("R13 disabled error pulse", int'(irq_err), 0);
    ie_err = 1'b1;
    step(1'b0);
    chk("R11 error after first stays silent", int'(irq_err), 0);
    pulse_load();
    chk("R13 errors counted with enable off", int'(err_count), 2);
    step(1'b0);
    chk("R11 load re-arms error pulse", int'(irq_err), 1);
    repeat (70) step(1'b1);

    pulse_load();
    repeat (4095) step(1'b1);
    chk("R9 no flag at full scale", int'(cnt_ovf), 0);
    step(1'b1);
    chk("R9 flag on saturation", int'(cnt_ovf), 1);
    chk("R12 saturation pulse", int'(irq_ovf), 1);
    step(1'b1);
    chk("R12 pulse lasts one cycle", int'(irq_ovf), 0);
    chk("R9 flag sticky", int'(cnt_ovf), 1);
    pulse_load();
    chk("R9 total held at full scale", int'(bit_count), 4095);
    chk("R8 load clears flag", int'(cnt_ovf), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule